// File: doc/BRIEF.md
# Wait-for-Interrupt Timeout Trap Controller

This block governs a wait-for-interrupt (WFI) instruction once decode has issued it. On the issue strobe it decides whether the WFI finishes at once, stalls the pipeline until an interrupt wake arrives, or is turned into an illegal-instruction exception. The decision depends on the current privilege level and the timeout-wait enable bit.

A WFI issued below machine level while timeout-wait is enabled is "timed". If no wake arrives within `LIMIT` cycles after issue, the block raises a one-cycle trap pulse instead of completing. Machine-level WFIs, and all WFIs while timeout-wait is clear, are untimed: they stall until a wake and then complete. `LIMIT` may be zero. In that case a timed WFI traps on the cycle after issue unless a wake is present on the issue cycle itself.

Privilege is a 2-bit code: 0 is user, 1 is supervisor and 3 (`MACHINE_MODE`) is machine. Cycle numbering below counts the issue cycle as cycle 0.

Top module: `wfi_timeout_trap`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `wfiStall`, `wfiDone` and `wfiTrap` are all low.
- R2: If `wakePending` is high in the same cycle as an accepted `wfiIssue`, then `wfiDone` pulses in cycle 1 and `wfiStall` never rises.
- R3: A WFI issued with `privMode` equal to 3 (machine) never traps. It holds `wfiStall` high from cycle 1 until the wake is sampled, and `wfiDone` pulses on the cycle after the wake, even if that is well past `LIMIT`.
- R4: A WFI issued while `twEnable` is 0 never traps, whatever its privilege level. It completes exactly as in R3.
- R5: A timed WFI (privilege 0 or 1, `twEnable` 1) that sees no wake in cycles 0 through `LIMIT` holds `wfiStall` high for exactly `LIMIT` cycles. `wfiTrap` then pulses in cycle `LIMIT`+1 and `wfiDone` does not pulse.
- R6: A timed WFI whose first wake falls in cycle k, with k no greater than `LIMIT`, pulses `wfiDone` in cycle k+1 and raises no trap.
- R7: When the wake falls in cycle `LIMIT`, the cycle in which the limit expires, completion wins. A wake in cycle `LIMIT`+1 comes too late, and the WFI traps.
- R8: With `LIMIT` equal to 0, a timed WFI with no wake on its issue cycle pulses `wfiTrap` in cycle 1 and never raises `wfiStall`.
- R9: `wfiDone` and `wfiTrap` are one-cycle pulses, one per accepted WFI. They are never high together, and `wfiStall` is low whenever either is high.
- R10: While `wfiStall` is high, a new `wfiIssue` is ignored, and changes to `privMode` or `twEnable` do not change whether the pending WFI is timed. Timing is fixed at issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wfiIssue | input | 1 | One-cycle strobe: a WFI has been issued |
| privMode | input | PRIV_W | Current privilege level (0 user, 1 supervisor, 3 machine) |
| twEnable | input | 1 | Timeout-wait enable bit |
| wakePending | input | 1 | An interrupt that should end the wait is pending |
| wfiStall | output | 1 | WFI waiting; hold the pipeline |
| wfiDone | output | 1 | One-cycle pulse: WFI completed normally |
| wfiTrap | output | 1 | One-cycle pulse: raise illegal-instruction exception |

## Verification
The bench builds two instances from the same stimulus: one with `LIMIT` = 5 and one with `LIMIT` = 0. The instance with a limit of 5 makes the stall window long enough to place a wake strictly inside it, exactly on the expiry cycle, and one cycle past it. It also leaves room to change the privilege level, the enable bit and the issue strobe in the middle of a wait. The zero-limit instance drives the same WFIs down the immediate-trap path. There, only a wake on the issue cycle avoids the exception.

// File: rtl/wfi_trap_pkg.sv
package wfi_trap_pkg;

  // Strobes from the wait controller to the timer datapath.
  typedef struct packed {
    logic load;     // start a new wait: capture timing class, count = 1
    logic step;     // one more waiting cycle elapsed
    logic clear;    // wait resolved: return counter to zero
    logic waiting;  // controller is in its waiting state
  } timerCmd_t;

endpackage

// File: rtl/wfi_timer_path.sv
module wfi_timer_path
  import wfi_trap_pkg::*;
#(
  parameter int LIMIT = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  input  logic      issueTimed,
  output logic      expire
);

  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(LIMIT);

  logic [CNT_W-1:0] elapsed;
  logic             timedQ;
  logic             activeTimed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
      timedQ  <= 1'b0;
    end else if (cmd.clear) begin
      elapsed <= '0;
      timedQ  <= 1'b0;
    end else if (cmd.load) begin
      elapsed <= CNT_W'(1);
      timedQ  <= issueTimed;
    end else if (cmd.step && timedQ) begin
      elapsed <= elapsed + CNT_W'(1);
    end
  end

  // On the issue cycle the live timing class applies with elapsed at zero.
  assign activeTimed = cmd.waiting ? timedQ : issueTimed;
  assign expire      = activeTimed && (elapsed == LIMIT_CNT);

endmodule

// File: rtl/wfi_wait_ctl.sv
module wfi_wait_ctl
  import wfi_trap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      issue,
  input  logic      wake,
  input  logic      expire,
  output timerCmd_t cmd,
  output logic      stall,
  output logic      donePulse,
  output logic      trapPulse
);

  typedef enum logic {ST_IDLE, ST_WAIT} waitState_e;

  waitState_e state, nextState;
  logic       doneNext, trapNext;

  always_comb begin
    nextState   = state;
    doneNext    = 1'b0;
    trapNext    = 1'b0;
    cmd         = '0;
    cmd.waiting = (state == ST_WAIT);
    unique case (state)
      ST_IDLE: begin
        if (issue) begin
          if (wake) begin
            doneNext = 1'b1;
          end else if (expire) begin
            trapNext = 1'b1;
          end else begin
            cmd.load  = 1'b1;
            nextState = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (wake) begin
          doneNext  = 1'b1;
          cmd.clear = 1'b1;
          nextState = ST_IDLE;
        end else if (expire) begin
          trapNext  = 1'b1;
          cmd.clear = 1'b1;
          nextState = ST_IDLE;
        end else begin
          cmd.step = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
      trapPulse <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= doneNext;
      trapPulse <= trapNext;
    end
  end

  assign stall = (state == ST_WAIT);

endmodule

// File: rtl/wfi_timeout_trap.sv
module wfi_timeout_trap
  import wfi_trap_pkg::*;
#(
  parameter int LIMIT        = 5,
  parameter int PRIV_W       = 2,
  parameter int MACHINE_MODE = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wfiIssue,
  input  logic [PRIV_W-1:0] privMode,
  input  logic              twEnable,
  input  logic              wakePending,
  output logic              wfiStall,
  output logic              wfiDone,
  output logic              wfiTrap
);

  localparam logic [PRIV_W-1:0] MACHINE_CODE = PRIV_W'(MACHINE_MODE);

  timerCmd_t timerCmd;
  logic      issueTimed;
  logic      expire;

  assign issueTimed = twEnable && (privMode != MACHINE_CODE);

  wfi_wait_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .issue     (wfiIssue),
    .wake      (wakePending),
    .expire    (expire),
    .cmd       (timerCmd),
    .stall     (wfiStall),
    .donePulse (wfiDone),
    .trapPulse (wfiTrap)
  );

  wfi_timer_path #(.LIMIT(LIMIT)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (timerCmd),
    .issueTimed (issueTimed),
    .expire     (expire)
  );

endmodule

// File: rtl/wfi_timeout_checks.sv
module wfi_timeout_checks #(
  parameter int LIMIT        = 5,
  parameter int PRIV_W       = 2,
  parameter int MACHINE_MODE = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wfiIssue,
  input logic [PRIV_W-1:0] privMode,
  input logic              twEnable,
  input logic              wakePending,
  input logic              wfiStall,
  input logic              wfiDone,
  input logic              wfiTrap
);

  // Length of the current run of stall cycles.
  logic [31:0] stallRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallRun <= '0;
    else       stallRun <= wfiStall ? stallRun + 32'd1 : 32'd0;
  end

  a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wfiDone && wfiTrap));

  a_r9_no_stall_on_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (wfiDone || wfiTrap) |-> !wfiStall);

  a_r2_wake_at_issue: assert property (@(posedge clk) disable iff (!rstN)
    (wfiIssue && !wfiStall && wakePending) |=> (wfiDone && !wfiStall));

  a_r3_machine_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    (wfiIssue && !wfiStall && privMode == PRIV_W'(MACHINE_MODE)) |=> !wfiTrap);

  a_r4_tw_clear_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    (wfiIssue && !wfiStall && !twEnable) |=> !wfiTrap);

  a_r6_wake_completes: assert property (@(posedge clk) disable iff (!rstN)
    (wfiStall && wakePending) |=> wfiDone);

  a_r5_trap_after_limit: assert property (@(posedge clk) disable iff (!rstN)
    wfiTrap |-> (stallRun == 32'(LIMIT)));

endmodule

bind wfi_timeout_trap wfi_timeout_checks #(
  .LIMIT(LIMIT), .PRIV_W(PRIV_W), .MACHINE_MODE(MACHINE_MODE)
) uChecks (
  .clk(clk), .rstN(rstN), .wfiIssue(wfiIssue), .privMode(privMode),
  .twEnable(twEnable), .wakePending(wakePending), .wfiStall(wfiStall),
  .wfiDone(wfiDone), .wfiTrap(wfiTrap)
);

// File: tb/tb_wfi_timeout_trap.sv
`timescale 1ns/1ps
module tb_wfi_timeout_trap;

  localparam int LIM_A = 5;
  localparam int LIM_B = 0;

  typedef struct {
    bit    isTrap;
    int    cyc;
    string req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issue = 1'b0;
  logic [1:0] privMode = 2'd0;
  logic       tw = 1'b0;
  logic       wake = 1'b0;
  logic       stallV [2];
  logic       doneV  [2];
  logic       trapV  [2];
  int         cyc = 0;
  int         checks = 0;
  int         failures = 0;
  expItem_t   expQ [2][$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wfi_timeout_trap #(.LIMIT(LIM_A)) dut (
    .clk(clk), .rstN(rstN), .wfiIssue(issue), .privMode(privMode),
    .twEnable(tw), .wakePending(wake),
    .wfiStall(stallV[0]), .wfiDone(doneV[0]), .wfiTrap(trapV[0]));

  wfi_timeout_trap #(.LIMIT(LIM_B)) dutZero (
    .clk(clk), .rstN(rstN), .wfiIssue(issue), .privMode(privMode),
    .twEnable(tw), .wakePending(wake),
    .wfiStall(stallV[1]), .wfiDone(doneV[1]), .wfiTrap(trapV[1]));

  task automatic expectEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Resolution of one WFI from the requirements: returns the cycle offset
  // (counted from the cycle after issue) at which the pulse is seen.
  function automatic int resolveAt(int lim, bit timed, int wakeAt, output bit isTrap);
    if (wakeAt >= 0 && (!timed || wakeAt <= lim)) begin
      isTrap = 1'b0;
      return wakeAt;
    end
    isTrap = 1'b1;
    return lim;
  endfunction

  // Monitor: pops the scoreboard whenever a pulse appears.
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 2; i++) begin
        if (doneV[i] || trapV[i]) begin
          expectEq("R9", "done and trap together", int'(doneV[i] && trapV[i]), 0);
          if (expQ[i].size() == 0) begin
            expectEq("R9", "unexpected pulse", 1, 0);
          end else begin
            expItem_t it;
            it = expQ[i].pop_front();
            expectEq(it.req, "pulse is trap", int'(trapV[i]), int'(it.isTrap));
            expectEq(it.req, "pulse cycle", cyc, it.cyc);
          end
        end
      end
    end
  end

  // Driver: issues one WFI, pushes expected pulses, checks stall each cycle.
  // A perturbation at cycle 2 can change privilege, enable and issue strobe.
  task automatic runWfi(logic [1:0] pm, logic t, int wakeAt, string req,
                        bit pert = 0, logic [1:0] pPm = 2'd0, logic pT = 1'b0,
                        logic pIss = 1'b0);
    bit timed;
    int res [2];
    bit isTrap [2];
    int c0;
    int horizon;
    timed = t && (pm != 2'd3);
    res[0] = resolveAt(LIM_A, timed, wakeAt, isTrap[0]);
    res[1] = resolveAt(LIM_B, timed, wakeAt, isTrap[1]);
    horizon = ((res[0] > res[1]) ? res[0] : res[1]) + 2;
    @(negedge clk);
    issue = 1'b1; privMode = pm; tw = t; wake = (wakeAt == 0);
    c0 = cyc + 1;
    for (int i = 0; i < 2; i++) begin
      expItem_t it;
      it.isTrap = isTrap[i]; it.cyc = c0 + res[i]; it.req = req;
      expQ[i].push_back(it);
    end
    for (int m = 0; m <= horizon; m++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        expectEq(req, (i == 0) ? "stall (limit 5)" : "stall (limit 0)",
                 int'(stallV[i]), int'(m < res[i]));
      issue = (pert && m + 1 == 2) ? pIss : 1'b0;
      if (pert && m + 1 == 2) begin privMode = pPm; tw = pT; end
      wake = (m + 1 == wakeAt);
    end
    issue = 1'b0; wake = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      expectEq("R1", "stall in reset", int'(stallV[i]), 0);
      expectEq("R1", "done in reset", int'(doneV[i]), 0);
      expectEq("R1", "trap in reset", int'(trapV[i]), 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      expectEq("R1", "stall after reset", int'(stallV[i]), 0);
      expectEq("R1", "done after reset", int'(doneV[i]), 0);
      expectEq("R1", "trap after reset", int'(trapV[i]), 0);
    end

    runWfi(2'd0, 1'b1, 0, "R2");          // wake on issue cycle: done in both
    runWfi(2'd3, 1'b1, 9, "R3");          // machine level, wake past limit
    runWfi(2'd0, 1'b0, 12, "R4");         // user, enable clear
    runWfi(2'd1, 1'b0, 3, "R4");          // supervisor, enable clear
    runWfi(2'd0, 1'b1, -1, "R5");         // user timed, no wake; zero limit covers R8
    runWfi(2'd1, 1'b1, -1, "R8");         // supervisor timed, no wake
    runWfi(2'd0, 1'b1, 3, "R6");          // wake inside window
    runWfi(2'd1, 1'b1, 1, "R6");          // wake on first waiting cycle
    runWfi(2'd0, 1'b1, 5, "R7");          // wake on expiry cycle: completion wins
    runWfi(2'd0, 1'b1, 6, "R7");          // wake one cycle late: trap
    // R10: re-issue plus a switch to a timed class mid-wait is ignored
    runWfi(2'd3, 1'b0, 8, "R10", 1'b1, 2'd0, 1'b1, 1'b1);
    // R10: dropping the enable and moving to machine mid-wait does not cancel timing
    runWfi(2'd0, 1'b1, -1, "R10", 1'b1, 2'd3, 1'b0, 1'b0);
    // back-to-back WFIs (R9: one pulse each)
    runWfi(2'd0, 1'b1, 0, "R9");
    runWfi(2'd0, 1'b1, 2, "R9");

    repeat (3) @(negedge clk);
    expectEq("R9", "missing pulses (limit 5)", expQ[0].size(), 0);
    expectEq("R9", "missing pulses (limit 0)", expQ[1].size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule